// File: doc/BRIEF.md
# Model-Specific Register Access Permission Checker

This block decides whether a guest access to a model-specific register (MSR) must leave the guest and trap to the hypervisor. A request carries a 32-bit MSR index, a read/write selector, the base address of a permission bitmap held in memory, and an enable that says whether MSR accesses are intercepted at all. When interception is enabled and the index falls in one of three supported windows, the block computes where that MSR's two permission bits sit in the bitmap. It fetches the byte that holds them through a simple byte-read port and tests the bit for the requested direction.

The three windows are packed back to back into one bitmap, each MSR taking two adjacent bits: the lower bit governs reads and the upper bit governs writes. An index outside every window always traps, and no memory read is made for it. When interception is disabled the block reports no trap, also without a memory read. The result is presented as a one-cycle `done` pulse with `vm_exit` valid in the same cycle. While a memory fetch is outstanding the block reports `busy`, and any new request offered then is dropped.

Top module: `msr_perm_check`

## Requirements
- R1: After reset `done`, `vm_exit`, `mem_rd_en` and `busy` are all 0.
- R2: With `msr_icpt_en` = 0, an accepted request gives `done` = 1 and `vm_exit` = 0 in the next cycle, and `mem_rd_en` stays 0.
- R3: An index in 0x0000_0000..0x0000_1FFF has bit index index*2. A read is issued at `bitmap_base` + bit_index/8, and the bit tested within the byte is bit_index mod 8.
- R4: An index in 0xC000_0000..0xC000_1FFF has bit index (8192 + index - 0xC000_0000)*2. The byte address and the bit position follow the rule of R3.
- R5: An index in 0xC001_0000..0xC001_1FFF has bit index (16384 + index - 0xC001_0000)*2. The byte address and the bit position follow the rule of R3.
- R6: With `msr_icpt_en` = 1, an index outside the three windows gives `done` = 1 and `vm_exit` = 1 in the next cycle, and `mem_rd_en` stays 0.
- R7: For an in-window index, `vm_exit` equals bit (bit_index mod 8) + `req_write` of the fetched byte. `req_write` = 0 selects a read and 1 selects a write.
- R8: An in-window request raises `mem_rd_en` for exactly one cycle, which is the first cycle of `busy`. `done` rises in the cycle after the one in which `mem_rd_valid` is seen while busy, and never earlier.
- R9: A request offered while `busy` is ignored, and `mem_rd_addr` holds while busy. A `mem_rd_valid` that arrives while idle produces no `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when not busy |
| req_index | input | 32 | MSR index to check |
| req_write | input | 1 | 0 = read access, 1 = write access |
| msr_icpt_en | input | 1 | MSR interception enable |
| bitmap_base | input | AW | Byte address of the permission bitmap |
| busy | output | 1 | A bitmap fetch is outstanding |
| done | output | 1 | One-cycle result strobe |
| vm_exit | output | 1 | The access must trap; valid with `done` |
| mem_rd_en | output | 1 | One-cycle byte read request |
| mem_rd_addr | output | AW | Byte address of the read |
| mem_rd_data | input | 8 | Returned byte |
| mem_rd_valid | input | 1 | `mem_rd_data` is valid this cycle |

## Verification
The assertions assume that the memory answers each read with exactly one `mem_rd_valid` pulse, possibly in the cycle right after the request. Any `mem_rd_valid` seen while busy is therefore taken to be the answer to the outstanding read. The bench's memory model keeps to this: it returns one response per read after a latency of one to three cycles, and it injects its stray `mem_rd_valid` pulses only while the block is idle. Expected trap decisions come from the bench's own window arithmetic and a hashed byte function that stands in for bitmap contents. Each window is swept at both ends for both access directions, along with the indices just past each window edge.

// File: rtl/msr_perm_pkg.sv
package msr_perm_pkg;

    // MSRs covered by each index window
    localparam int RANGE_SPAN   = 8192;
    localparam int NUM_WIN      = 3;
    localparam int BITS_PER_MSR = 2;
    localparam int SPAN_W       = $clog2(RANGE_SPAN);
    localparam int BIT_IDX_W    = $clog2(NUM_WIN * RANGE_SPAN * BITS_PER_MSR);
    localparam int OFF_W        = BIT_IDX_W - 3;

    typedef struct packed {
        logic             hit;
        logic [OFF_W-1:0] byte_off;
        logic [2:0]       bit_pos;
    } map_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_WAIT = 1'b1
    } state_e;

    // First MSR index of window k; window order sets its bitmap slot
    function automatic logic [31:0] win_start(input int k);
        case (k)
            0:       return 32'h0000_0000;
            1:       return 32'hC000_0000;
            default: return 32'hC001_0000;
        endcase
    endfunction

endpackage

// File: rtl/msr_perm_map.sv
module msr_perm_map
    import msr_perm_pkg::*;
(
    input  logic [31:0] idx,
    output map_t        map
);

    logic [NUM_WIN-1:0]                hit;
    logic [NUM_WIN-1:0][BIT_IDX_W-1:0] bidx;

    // One comparator and offset adder per window
    for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
        logic [31:0] rel;
        assign rel     = idx - win_start(k);
        assign hit[k]  = (rel < 32'(RANGE_SPAN));
        assign bidx[k] = {(BIT_IDX_W-1)'(k * RANGE_SPAN) + (BIT_IDX_W-1)'(rel[SPAN_W-1:0]), 1'b0};
    end

    // Windows are disjoint, so at most one contributes
    always_comb begin
        map = '0;
        for (int k = 0; k < NUM_WIN; k++) begin
            if (hit[k]) begin
                map.hit      = 1'b1;
                map.byte_off = bidx[k][BIT_IDX_W-1:3];
                map.bit_pos  = bidx[k][2:0];
            end
        end
    end

endmodule

// File: rtl/msr_perm_ctrl.sv
module msr_perm_ctrl
    import msr_perm_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          msr_icpt_en,
    input  logic [AW-1:0] bitmap_base,
    input  map_t          map,
    input  logic [7:0]    mem_rd_data,
    input  logic          mem_rd_valid,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    output logic          busy,
    output logic          done,
    output logic          vm_exit
);

    state_e     state;
    logic [2:0] sel_q;
    logic       accept;

    assign accept = req_valid && (state == S_IDLE);
    assign busy   = (state == S_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            sel_q       <= '0;
            mem_rd_en   <= 1'b0;
            mem_rd_addr <= '0;
            done        <= 1'b0;
            vm_exit     <= 1'b0;
        end else begin
            done      <= 1'b0;
            mem_rd_en <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (accept) begin
                        if (!msr_icpt_en) begin
                            done    <= 1'b1;
                            vm_exit <= 1'b0;
                        end else if (!map.hit) begin
                            done    <= 1'b1;
                            vm_exit <= 1'b1;
                        end else begin
                            state       <= S_WAIT;
                            mem_rd_en   <= 1'b1;
                            mem_rd_addr <= bitmap_base + AW'(map.byte_off);
                            // even bit position, so adding the direction stays in the byte
                            sel_q       <= map.bit_pos + {2'b00, req_write};
                        end
                    end
                end
                S_WAIT: begin
                    if (mem_rd_valid) begin
                        done    <= 1'b1;
                        vm_exit <= mem_rd_data[sel_q];
                        state   <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/msr_perm_check.sv
module msr_perm_check
    import msr_perm_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [31:0]   req_index,
    input  logic          req_write,
    input  logic          msr_icpt_en,
    input  logic [AW-1:0] bitmap_base,
    output logic          busy,
    output logic          done,
    output logic          vm_exit,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [7:0]    mem_rd_data,
    input  logic          mem_rd_valid
);

    map_t idx_map;

    msr_perm_map u_map (
        .idx (req_index),
        .map (idx_map)
    );

    msr_perm_ctrl #(.AW(AW)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .msr_icpt_en  (msr_icpt_en),
        .bitmap_base  (bitmap_base),
        .map          (idx_map),
        .mem_rd_data  (mem_rd_data),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_en    (mem_rd_en),
        .mem_rd_addr  (mem_rd_addr),
        .busy         (busy),
        .done         (done),
        .vm_exit      (vm_exit)
    );

endmodule

// File: rtl/msr_perm_sva.sv
module msr_perm_sva #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          msr_icpt_en,
    input logic          busy,
    input logic          done,
    input logic          vm_exit,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_rd_addr,
    input logic          mem_rd_valid
);

    // R2
    bypass_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && !msr_icpt_en) |=> (done && !vm_exit && !mem_rd_en));

    // R8
    read_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> busy);

    // R8
    read_on_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> mem_rd_en);

    // R8
    done_after_data_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_rd_valid) |=> (done && !busy));

    // R8
    no_early_done_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_rd_valid) |=> (!done && busy));

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mem_rd_addr));

endmodule

bind msr_perm_check msr_perm_sva #(.AW(AW)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .msr_icpt_en  (msr_icpt_en),
    .busy         (busy),
    .done         (done),
    .vm_exit      (vm_exit),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid)
);

// File: tb/tb_msr_perm_check.sv
module tb_msr_perm_check;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_index = '0;
    logic        req_write = 1'b0;
    logic        msr_icpt_en = 1'b0;
    logic [31:0] bitmap_base = '0;
    logic        busy, done, vm_exit, mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [7:0]  mem_rd_data;
    logic        mem_rd_valid;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    msr_perm_check #(.AW(32)) dut (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_index    (req_index),
        .req_write    (req_write),
        .msr_icpt_en  (msr_icpt_en),
        .bitmap_base  (bitmap_base),
        .busy         (busy),
        .done         (done),
        .vm_exit      (vm_exit),
        .mem_rd_en    (mem_rd_en),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_data  (mem_rd_data),
        .mem_rd_valid (mem_rd_valid)
    );

    // Bitmap contents stand-in: hashed byte per address
    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        logic [31:0] t;
        t = a * 32'd2654435761;
        return t[23:16] ^ a[7:0];
    endfunction

    // Memory model with programmable latency and stray-pulse injection
    int          lat   = 1;
    logic        stray = 1'b0;
    int          cnt;
    int          reads;
    logic [31:0] pend;

    always @(posedge clk) begin
        if (rst) begin
            cnt          <= 0;
            reads        <= 0;
            mem_rd_valid <= 1'b0;
            mem_rd_data  <= 8'h00;
            pend         <= '0;
        end else begin
            mem_rd_valid <= stray;
            if (stray) mem_rd_data <= 8'hFF;
            if (cnt != 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) begin
                    mem_rd_valid <= 1'b1;
                    mem_rd_data  <= mem_byte(pend);
                end
            end
            if (mem_rd_en) begin
                cnt   <= lat;
                pend  <= mem_rd_addr;
                reads <= reads + 1;
            end
        end
    end

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    task automatic do_req(input logic [31:0] idx, input logic wr, input logic en, input bit poke);
        longint      bi;
        bit          hit;
        string       rq;
        logic [31:0] ea;
        logic [7:0]  b;
        logic        exp;
        int          r0;
        logic        prev;
        bit          seen;
        hit = 1'b1;
        bi  = 0;
        if (idx < 32'h0000_2000) begin
            bi = longint'(idx) * 2; rq = "R3";
        end else if (idx >= 32'hC000_0000 && idx < 32'hC000_2000) begin
            bi = (8192 + longint'(idx) - 64'hC000_0000) * 2; rq = "R4";
        end else if (idx >= 32'hC001_0000 && idx < 32'hC001_2000) begin
            bi = (16384 + longint'(idx) - 64'hC001_0000) * 2; rq = "R5";
        end else begin
            hit = 1'b0; rq = "R6";
        end
        if (!en) rq = "R2";
        ea  = bitmap_base + 32'(bi / 8);
        b   = mem_byte(ea);
        exp = b[int'(bi % 8) + int'(wr)];
        r0  = reads;
        lat = int'(idx % 3) + 1;

        req_valid   = 1'b1;
        req_index   = idx;
        req_write   = wr;
        msr_icpt_en = en;
        @(negedge clk);
        req_valid = 1'b0;
        if (!en || !hit) begin
            chk(rq, "done", done, 1);
            chk(rq, "vm_exit", vm_exit, en ? 1 : 0);
            chk(rq, "mem_rd_en", mem_rd_en, 0);
        end else begin
            chk("R8", "done early", done, 0);
            chk("R8", "rd_en pulse", mem_rd_en, 1);
            chk(rq, "byte address", mem_rd_addr, ea);
            if (poke) begin
                req_valid = 1'b1;
                req_index = idx ^ 32'h1;
                req_write = ~wr;
            end
            seen = 1'b0;
            prev = mem_rd_valid;
            for (int w = 0; w < 20; w++) begin
                @(negedge clk);
                req_valid = 1'b0;
                if (!seen && mem_rd_en) chk("R8", "second rd_en", mem_rd_en, 0);
                if (done) begin
                    seen = 1'b1;
                    break;
                end
                prev = mem_rd_valid;
            end
            chk("R8", "done seen", seen, 1);
            chk("R8", "data valid before done", prev, 1);
            chk("R7", $sformatf("exit idx=%0h wr=%0d", idx, wr), vm_exit, exp);
            @(negedge clk);
            chk("R9", "single read per request", reads - r0, 1);
            chk("R9", "no extra done", done, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "done", done, 0);
        chk("R1", "vm_exit", vm_exit, 0);
        chk("R1", "mem_rd_en", mem_rd_en, 0);
        chk("R1", "busy", busy, 0);

        // Window sweeps: both ends of each window, both directions
        for (int r = 0; r < 3; r++) begin
            bitmap_base = (r == 1) ? 32'h8001_2345 : 32'h0004_3000;
            for (int k = 0; k < 1024; k++) begin
                int off;
                logic [31:0] start;
                off   = (k < 512) ? k : (8192 - 1024 + k);
                start = (r == 0) ? 32'h0000_0000 : (r == 1) ? 32'hC000_0000 : 32'hC001_0000;
                for (int wr = 0; wr < 2; wr++)
                    do_req(start + 32'(off), wr[0], 1'b1, (k % 97) == 0);
            end
        end

        // R6 indices just outside each window edge
        begin
            logic [31:0] outs [8];
            outs = '{32'h0000_2000, 32'hBFFF_FFFF, 32'hC000_2000, 32'hC000_FFFF,
                     32'hC001_2000, 32'hFFFF_FFFF, 32'h4000_0000, 32'hC000_1FFF + 32'h1};
            for (int i = 0; i < 8; i++)
                for (int wr = 0; wr < 2; wr++)
                    do_req(outs[i], wr[0], 1'b1, 1'b0);
        end

        // R2 interception disabled, in and out of window
        do_req(32'h0000_0010, 1'b0, 1'b0, 1'b0);
        do_req(32'hC000_0081, 1'b1, 1'b0, 1'b0);
        do_req(32'hC001_1FFF, 1'b1, 1'b0, 1'b0);
        do_req(32'h1234_5678, 1'b0, 1'b0, 1'b0);

        // R9 stray valid while idle gives no done
        stray = 1'b1;
        @(negedge clk);
        stray = 1'b0;
        @(negedge clk);
        chk("R9", "stray valid done", done, 0);
        @(negedge clk);
        chk("R9", "stray valid done late", done, 0);
        do_req(32'h0000_1FFF, 1'b1, 1'b1, 1'b0);

        summary();
        $finish;
    end

endmodule